// File: doc/BRIEF.md
# Nibble ALU with Condition Flags

This block combines a 4-bit arithmetic and logic unit with a 4-bit condition code register. Each cycle in which an operation is issued, the unit combines two operands with the current carry flag and produces a result at once. On the next clock edge it updates the carry and branch flags according to the class of the operation. Arithmetic, shift and rotate operations write both flags. Boolean operations write only the branch flag.

The carry flag has three roles. It holds the carry out of an addition, the borrow out of a subtraction, and an extra fifth bit that shifts and rotates move data through. The branch flag is shown on a dedicated output that a sequencer uses to decide conditional jumps. When no operation is issued, a small set of direct commands can set, toggle or load the flags and clear the interrupt-enable flag. Operand fetch and program-counter update belong to neighbouring blocks.

Top module: `nibalu_top`

## Requirements
- R1: Asynchronous active-low reset clears all four flag bits, so `branch_take` is 0 and interrupts are disabled.
- R2: Op 0 (add) gives `a_in+b_in` and op 1 (add with carry) gives `a_in+b_in+C`. Both take the low 4 bits and set C to the carry out. C is flag bit 3.
- R3: Op 2 (subtract) gives `a_in-b_in` and op 3 (subtract with borrow) gives `a_in-b_in-C`. Both take the low 4 bits and set C to 1 exactly when a borrow occurred.
- R4: Op 4 (AND), op 5 (OR) and op 6 (XOR) give the bitwise result and leave C unchanged.
- R5: After ops 0-3 and 8-11, the branch flag B (bit 2) equals the new C. After ops 4-6, B is 1 exactly when the result is zero.
- R6: Op 8 shifts `a_in` left with a zero fill and op 9 shifts it right with a zero fill. In both, the bit shifted out goes into C.
- R7: Op 10 rotates `a_in` left through C and op 11 rotates it right through C. The old C enters the vacated bit and the bit shifted out becomes the new C.
- R8: No ALU operation changes the interrupt-enable flag I (bit 1). Bit 0 always reads 0.
- R9: When `op_valid` is low, command 1 sets B and C, command 2 toggles B, and command 4 clears I. Each leaves the other flags as they are.
- R10: When `op_valid` is low, command 3 loads bits 3..1 from `flag_load`, and bit 0 stays 0.
- R11: While `op_valid` is high, any flag command is ignored. With `op_valid` low and command 0, or with any unused op code (7, 12-15) issued, the flags hold. An unused op code drives `result` equal to `a_in`.
- R12: `branch_take` equals the branch flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue the ALU operation in `op_sel` this cycle |
| op_sel | input | 4 | Operation code |
| a_in | input | DATA_W | First operand |
| b_in | input | DATA_W | Second operand |
| flag_cmd | input | 3 | Direct flag command, used only when `op_valid` is low |
| flag_load | input | 4 | Value written by the load command |
| result | output | DATA_W | Combinational ALU result |
| ccr | output | 4 | Flags {C, B, I, 0} |
| branch_take | output | 1 | Conditional-branch decision |

## Verification
The checker runs on every cycle. It checks that the reserved bit stays at zero, that Boolean operations keep the carry, and that no ALU operation touches interrupt enable. It also checks that after carry-class operations the branch flag follows the new carry, and that after Boolean operations it reflects a zero result. It covers the hold behaviour of idle cycles and the interrupt-disable command as well. The exact arithmetic values can only be shown by the bench's scenarios: sums and differences with and without carry-in, borrow detection, and the bit patterns of shifts and rotates. The bench scenarios also cover reset, command priority against an issued operation, and the full-register load.

// File: rtl/nibalu_pkg.sv
package nibalu_pkg;

   localparam int CCR_W   = 4;
   localparam int CCR_C   = 3;
   localparam int CCR_B   = 2;
   localparam int CCR_I   = 1;
   localparam int CCR_RSV = 0;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBB = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_SHL  = 4'd8,
      OP_SHR  = 4'd9,
      OP_ROL  = 4'd10,
      OP_ROR  = 4'd11
   } alu_op_e;

   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_SET_BC  = 3'd1,
      FC_TOG_B   = 3'd2,
      FC_LOAD    = 3'd3,
      FC_DIS_INT = 3'd4
   } flag_cmd_e;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_CARRY = 2'd1,
      CLS_BOOL  = 2'd2
   } op_cls_e;

endpackage

// File: rtl/nibalu_adder.sv
module nibalu_adder #(
   parameter int DATA_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              ci,
   output logic [DATA_W-1:0] sum,
   output logic              co
);

   localparam int EXT_W = DATA_W + 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = ci;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign co = chain[DATA_W];
      end else begin : g_flat
         logic [EXT_W-1:0] total;
         assign total = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
         assign sum   = total[DATA_W-1:0];
         assign co    = total[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/nibalu_core.sv
module nibalu_core
   import nibalu_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              res_zero,
   output op_cls_e           cls
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] add_y;
   logic              add_ci;
   logic [DATA_W-1:0] add_sum;
   logic              add_co;

   always_comb begin
      add_y  = b;
      add_ci = 1'b0;
      case (op_sel)
         OP_ADDC: add_ci = cin;
         OP_SUB: begin
            add_y  = ~b;
            add_ci = 1'b1;
         end
         OP_SUBB: begin
            add_y  = ~b;
            add_ci = ~cin;
         end
         default: ;
      endcase
   end

   nibalu_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_add (
      .x   (a),
      .y   (add_y),
      .ci  (add_ci),
      .sum (add_sum),
      .co  (add_co)
   );

   always_comb begin
      res  = a;
      cout = cin;
      cls  = CLS_NONE;
      case (op_sel)
         OP_ADD, OP_ADDC: begin
            res  = add_sum;
            cout = add_co;
            cls  = CLS_CARRY;
         end
         OP_SUB, OP_SUBB: begin
            res  = add_sum;
            cout = ~add_co;
            cls  = CLS_CARRY;
         end
         OP_AND: begin
            res = a & b;
            cls = CLS_BOOL;
         end
         OP_OR: begin
            res = a | b;
            cls = CLS_BOOL;
         end
         OP_XOR: begin
            res = a ^ b;
            cls = CLS_BOOL;
         end
         OP_SHL: begin
            res  = {a[MSB-1:0], 1'b0};
            cout = a[MSB];
            cls  = CLS_CARRY;
         end
         OP_SHR: begin
            res  = {1'b0, a[MSB:1]};
            cout = a[0];
            cls  = CLS_CARRY;
         end
         OP_ROL: begin
            res  = {a[MSB-1:0], cin};
            cout = a[MSB];
            cls  = CLS_CARRY;
         end
         OP_ROR: begin
            res  = {cin, a[MSB:1]};
            cout = a[0];
            cls  = CLS_CARRY;
         end
         default: ;
      endcase
   end

   assign res_zero = (res == '0);

endmodule

// File: rtl/nibalu_flagreg.sv
module nibalu_flagreg
   import nibalu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alu_en,
   input  op_cls_e          cls,
   input  logic             new_c,
   input  logic             res_zero,
   input  logic [2:0]       cmd,
   input  logic [CCR_W-1:0] load_val,
   output logic [CCR_W-1:0] ccr_q
);

   logic [CCR_W-1:0] ccr_d;

   always_comb begin
      ccr_d = ccr_q;
      if (alu_en) begin
         case (cls)
            CLS_CARRY: begin
               ccr_d[CCR_C] = new_c;
               ccr_d[CCR_B] = new_c;
            end
            CLS_BOOL: ccr_d[CCR_B] = res_zero;
            default: ;
         endcase
      end else begin
         case (cmd)
            FC_SET_BC: begin
               ccr_d[CCR_C] = 1'b1;
               ccr_d[CCR_B] = 1'b1;
            end
            FC_TOG_B:   ccr_d[CCR_B] = ~ccr_q[CCR_B];
            FC_LOAD:    ccr_d = load_val;
            FC_DIS_INT: ccr_d[CCR_I] = 1'b0;
            default: ;
         endcase
      end
      ccr_d[CCR_RSV] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ccr_q <= '0;
      else        ccr_q <= ccr_d;
   end

endmodule

// File: rtl/nibalu_top.sv
module nibalu_top
   import nibalu_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [2:0]        flag_cmd,
   input  logic [3:0]        flag_load,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        ccr,
   output logic              branch_take
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("nibalu_top: DATA_W must be at least 2");
      end
   endgenerate

   logic    alu_cout;
   logic    alu_zero;
   op_cls_e alu_cls;

   nibalu_core #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_core (
      .op_sel   (op_sel),
      .a        (a_in),
      .b        (b_in),
      .cin      (ccr[CCR_C]),
      .res      (result),
      .cout     (alu_cout),
      .res_zero (alu_zero),
      .cls      (alu_cls)
   );

   nibalu_flagreg u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .alu_en   (op_valid),
      .cls      (alu_cls),
      .new_c    (alu_cout),
      .res_zero (alu_zero),
      .cmd      (flag_cmd),
      .load_val (flag_load),
      .ccr_q    (ccr)
   );

   assign branch_take = ccr[CCR_B];

endmodule

// File: rtl/nibalu_chk.sv
module nibalu_chk
   import nibalu_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_sel,
   input logic [2:0]        flag_cmd,
   input logic [DATA_W-1:0] result,
   input logic [3:0]        ccr
);

   logic is_bool, is_carry, idle_none, idle_di;

   assign is_bool   = op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR);
   assign is_carry  = op_valid && (op_sel <= 4'd3 || (op_sel >= 4'd8 && op_sel <= 4'd11));
   assign idle_none = !op_valid && flag_cmd == FC_NONE;
   assign idle_di   = !op_valid && flag_cmd == FC_DIS_INT;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ccr[CCR_RSV] == 1'b0); // R8

   AST_BOOL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      is_bool |=> ccr[CCR_C] == $past(ccr[CCR_C])); // R4

   AST_BOOL_BRANCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      is_bool |=> ccr[CCR_B] == ($past(result) == '0)); // R5

   AST_CARRY_BRANCH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      is_carry |=> ccr[CCR_B] == ccr[CCR_C]); // R5

   AST_ALU_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> $stable(ccr[CCR_I])); // R8

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_none |=> $stable(ccr)); // R11

   AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_di |=> ccr[CCR_I] == 1'b0 && ccr[3:2] == $past(ccr[3:2])); // R9

endmodule

bind nibalu_top nibalu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_sel   (op_sel),
   .flag_cmd (flag_cmd),
   .result   (result),
   .ccr      (ccr)
);

// File: tb/nibalu_top_tb.sv
`timescale 1ns/1ps
module nibalu_top_tb;

   localparam real CLK_NS = 8.0;
   localparam int  NVEC   = 21;

   // {op, a, b, carry-in, expected result, expected ccr with I preloaded to 1}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h0_7_8_1_F_2, 24'h0_9_8_0_1_E, 24'h1_F_0_1_0_E, 24'h1_3_4_1_8_2,
      24'h2_5_3_1_2_2, 24'h2_3_5_0_E_E, 24'h3_5_5_1_F_E, 24'h3_6_2_1_3_2,
      24'h4_C_A_1_8_A, 24'h4_5_A_0_0_6, 24'h5_0_0_1_0_E, 24'h6_F_5_0_A_2,
      24'h6_9_9_1_0_E, 24'h8_9_0_1_2_E, 24'h8_4_0_1_8_2, 24'h9_3_0_0_1_E,
      24'h9_8_0_1_4_2, 24'hA_5_0_1_B_2, 24'hA_8_0_0_0_E, 24'hB_A_0_1_D_2,
      24'hB_1_0_0_0_E
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [3:0] a_in = 4'd0;
   logic [3:0] b_in = 4'd0;
   logic [2:0] flag_cmd = 3'd0;
   logic [3:0] flag_load = 4'd0;
   logic [3:0] result;
   logic [3:0] ccr;
   logic       branch_take;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   nibalu_top u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .a_in(a_in), .b_in(b_in), .flag_cmd(flag_cmd), .flag_load(flag_load),
      .result(result), .ccr(ccr), .branch_take(branch_take)
   );

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_cmd(input logic [2:0] c, input logic [3:0] ld);
      op_valid = 1'b0; flag_cmd = c; flag_load = ld;
      step();
      flag_cmd = 3'd0;
   endtask

   initial begin
      #(CLK_NS * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      string tag;
      step(); step();
      chk("R1 ccr after reset", ccr, 4'h0);
      chk("R1 branch_take after reset", {3'b0, branch_take}, 4'h0);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NVEC; i++) begin
         logic [3:0] op, va, vb, vc, vr, vf;
         {op, va, vb, vc, vr, vf} = VEC[i];
         tag = (op < 4'd2) ? "R2" : (op < 4'd4) ? "R3" : (op < 4'd7) ? "R4" :
               (op < 4'd10) ? "R6" : "R7";
         idle_cmd(3'd3, {vc[0], 3'b010});
         op_valid = 1'b1; op_sel = op; a_in = va; b_in = vb;
         #1;
         chk($sformatf("%s result vec %0d", tag, i), result, vr);
         step();
         op_valid = 1'b0;
         chk($sformatf("%s carry vec %0d", tag, i), {3'b0, ccr[3]}, {3'b0, vf[3]});
         chk($sformatf("R5 branch vec %0d", i), {3'b0, ccr[2]}, {3'b0, vf[2]});
         chk($sformatf("R8 ie/rsvd vec %0d", i), {2'b0, ccr[1:0]}, {2'b0, vf[1:0]});
         chk($sformatf("R12 branch_take vec %0d", i), {3'b0, branch_take}, {3'b0, vf[2]});
      end

      // direct commands
      idle_cmd(3'd3, 4'h0);
      chk("R10 load zero", ccr, 4'h0);
      idle_cmd(3'd1, 4'h0);
      chk("R9 set B and C", ccr, 4'hC);
      chk("R12 branch_take after set", {3'b0, branch_take}, 4'h1);
      idle_cmd(3'd2, 4'h0);
      chk("R9 toggle B off", ccr, 4'h8);
      chk("R12 branch_take after toggle", {3'b0, branch_take}, 4'h0);
      idle_cmd(3'd2, 4'h0);
      chk("R9 toggle B on", ccr, 4'hC);
      idle_cmd(3'd3, 4'hF);
      chk("R10 load all ones, bit0 stays 0", ccr, 4'hE);
      idle_cmd(3'd4, 4'h0);
      chk("R9 disable interrupts", ccr, 4'hC);

      // command ignored while an op is issued: AND 3,5 = 1, B cleared, C kept
      op_valid = 1'b1; op_sel = 4'd4; a_in = 4'h3; b_in = 4'h5;
      flag_cmd = 3'd3; flag_load = 4'h0;
      step();
      op_valid = 1'b0; flag_cmd = 3'd0;
      chk("R11 command ignored during op", ccr, 4'h8);
      idle_cmd(3'd0, 4'hF);
      chk("R11 idle holds flags", ccr, 4'h8);

      // unused op code passes a_in and holds flags
      op_valid = 1'b1; op_sel = 4'd13; a_in = 4'h6; b_in = 4'h9;
      #1;
      chk("R11 unused op result", result, 4'h6);
      step();
      op_valid = 1'b0;
      chk("R11 unused op holds flags", ccr, 4'h8);

      // reset in mid-run
      idle_cmd(3'd3, 4'hE);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset clears", ccr, 4'h0);
      step();
      rst_n = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule